// File: doc/BRIEF.md
# Serial Frame Transmitter with Parity Slot and Line Break

This block drives an asynchronous serial line from a single data holding register. A word written over a valid/ready handshake is turned into one frame: a low start bit, a fixed number of data slots sent least significant bit first, and one high stop bit. Each bit lasts exactly one period of an externally supplied baud tick. When parity is enabled it does not lengthen the frame. It takes over the top slot, so the top bit of the written word is dropped.

A line-bus mode adds a break character. A pulse on the break request queues it. At the next frame boundary the transmitter sends a long run of low bits and then a single high bit, so that a receiver can find the next start bit. In this mode the slot count is forced to the short setting. The holding register frees as soon as the shifter has taken its word, so a second word can wait while the first is on the line and frames follow back to back.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset `tx` is 1, `busy` is 0 and `wr_ready` is 1. Whenever `busy` is 0, `tx` is 1.
- R2: With `cfg_wide`=0 and `cfg_par_en`=0, a frame is 10 bits: 0, then `wr_data[7:0]` starting at bit 0, then 1.
- R3: With `cfg_wide`=0 and `cfg_par_en`=1, a frame is 10 bits: 0, then `wr_data[6:0]` starting at bit 0, then the parity bit, then 1. `wr_data[7]` never appears on the line.
- R4: With `cfg_wide`=1 and `cfg_par_en`=0, a frame is 11 bits: 0, then `wr_data[8:0]` starting at bit 0, then 1.
- R5: With `cfg_wide`=1 and `cfg_par_en`=1, a frame is 11 bits: 0, then `wr_data[7:0]` starting at bit 0, then the parity bit, then 1.
- R6: With `cfg_par_odd`=0 the parity bit makes the number of ones over the sent data bits and the parity bit even. With `cfg_par_odd`=1 it makes that number odd. For example, data 0x35 gives parity 0 for even and 1 for odd.
- R7: `tx` changes only on a clock edge where `baud_tick` is 1. A word that is accepted while the line is idle starts its start bit on the next such edge, and each later bit takes one tick.
- R8: `wr_ready` falls on the edge that accepts a word. It rises again on the edge where the shifter loads that word. A waiting word sends its start bit on the tick that follows the previous stop bit.
- R9: With `cfg_lin_en`=1, a one-cycle `brk_req` pulse sends 13 bits of 0 followed by one bit of 1, with `busy` held at 1 for those 14 ticks.
- R10: With `cfg_lin_en`=0, `brk_req` has no effect: the line stays high and `busy` stays 0.
- R11: A break requested during a frame starts on the tick after that frame's stop bit. A pending break goes out before a word that is waiting in the holding register.
- R12: With `cfg_lin_en`=1 the frame uses the `cfg_wide`=0 format whatever the value of `cfg_wide`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| cfg_wide | input | 1 | 1 selects 9 data slots, 0 selects 8 |
| cfg_par_en | input | 1 | Put parity in the top slot |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_lin_en | input | 1 | Enable break mode and force 8 slots |
| brk_req | input | 1 | Pulse to queue a break character |
| wr_valid | input | 1 | Write request for the holding register |
| wr_data | input | 9 | Word to send |
| wr_ready | output | 1 | Holding register is empty |
| tx | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame or break is on the line |

## Verification
The hardest case to reach is a break request made in the middle of a frame while another word is already waiting in the holding register. In that case the pending break and the waiting word compete at the same stop-bit boundary. The bench controls every baud tick itself. It loads the first frame, writes a second word as soon as `wr_ready` rises, and pulses the break request after three ticks. It then checks, tick by tick, that the rest of the first frame, the whole break and the waiting word come out in that order with no idle bit between them.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef struct packed {
    logic wide;
    logic par_en;
    logic par_odd;
    logic lin_en;
  } sft_cfg_t;

  function automatic int sft_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sft_hold.sv
module sft_hold #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] word
);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      word <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr_valid && !full) begin
      full <= 1'b1;
      word <= wr_data;
    end
  end

endmodule

// File: rtl/sft_framer.sv
module sft_framer #(
  parameter int DATA_W    = 9,
  parameter int BRK_ZEROS = 13,
  parameter int FW        = 14,
  parameter int LW        = 4
) (
  input  logic              [DATA_W-1:0] data,
  input  sft_pkg::sft_cfg_t              cfg,
  input  logic                           sel_brk,
  output logic              [FW-1:0]     frame,
  output logic              [LW-1:0]     flen
);

  int   nslots;
  logic par_b;

  always_comb begin
    nslots = (cfg.wide && !cfg.lin_en) ? DATA_W : DATA_W - 1;
    par_b  = cfg.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nslots - 1) par_b = par_b ^ data[i];
    end
    frame = '1;
    if (sel_brk) begin
      for (int i = 0; i < FW; i++) begin
        if (i < BRK_ZEROS) frame[i] = 1'b0;
      end
      flen = LW'(BRK_ZEROS + 1);
    end else begin
      frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
        if (i < nslots)
          frame[i+1] = (cfg.par_en && (i == nslots - 1)) ? par_b : data[i];
      end
      flen = LW'(nslots + 2);
    end
  end

endmodule

// File: rtl/sft_shifter.sv
module sft_shifter #(
  parameter int FW = 14,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          have_work,
  input  logic [FW-1:0] frame,
  input  logic [LW-1:0] flen,
  output logic          take,
  output logic          tx,
  output logic          busy
);

  logic [FW-1:0] sr;
  logic [LW-1:0] left;
  logic          more;

  assign more = busy && (left > LW'(1));
  assign take = tick && !more && have_work;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx   <= 1'b1;
      busy <= 1'b0;
      sr   <= '1;
      left <= '0;
    end else if (tick) begin
      if (more) begin
        tx   <= sr[1];
        sr   <= {1'b1, sr[FW-1:1]};
        left <= left - LW'(1);
      end else if (have_work) begin
        tx   <= frame[0];
        sr   <= frame;
        left <= flen;
        busy <= 1'b1;
      end else begin
        tx   <= 1'b1;
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int DATA_W    = 9,
  parameter int BRK_ZEROS = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              cfg_wide,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_lin_en,
  input  logic              brk_req,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              tx,
  output logic              busy
);

  localparam int FW = sft_pkg::sft_max(DATA_W + 2, BRK_ZEROS + 1);
  localparam int LW = $clog2(FW + 1);

  sft_pkg::sft_cfg_t cfg;
  logic              full, brk_pend, take;
  logic [DATA_W-1:0] word;
  logic [FW-1:0]     frame;
  logic [LW-1:0]     flen;

  assign cfg      = '{wide: cfg_wide, par_en: cfg_par_en,
                      par_odd: cfg_par_odd, lin_en: cfg_lin_en};
  assign wr_ready = !full;

  always_ff @(posedge clk) begin
    if (rst) brk_pend <= 1'b0;
    else     brk_pend <= (brk_pend && !take) || (brk_req && cfg_lin_en);
  end

  sft_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .take(take && !brk_pend), .full(full), .word(word)
  );

  sft_framer #(.DATA_W(DATA_W), .BRK_ZEROS(BRK_ZEROS), .FW(FW), .LW(LW)) u_framer (
    .data(word), .cfg(cfg), .sel_brk(brk_pend), .frame(frame), .flen(flen)
  );

  sft_shifter #(.FW(FW), .LW(LW)) u_shift (
    .clk(clk), .rst(rst), .tick(baud_tick), .have_work(full || brk_pend),
    .frame(frame), .flen(flen), .take(take), .tx(tx), .busy(busy)
  );

endmodule

// File: rtl/sft_checker.sv
module sft_checker (
  input logic clk,
  input logic rst,
  input logic baud_tick,
  input logic wr_valid,
  input logic wr_ready,
  input logic tx,
  input logic busy
);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> tx);

  // R7
  tx_on_tick_chk: assert property (@(posedge clk) disable iff (rst) !baud_tick |=> $stable(tx));

  // R7
  busy_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !baud_tick) |=> !busy);

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> !wr_ready);

  // R8
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_ready && !baud_tick) |=> !wr_ready);

endmodule

bind serial_frame_tx sft_checker u_sft_checker (
  .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .tx(tx), .busy(busy)
);

// File: tb/serial_frame_tx_test.sv
module serial_frame_tx_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       cfg_wide = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_lin_en = 1'b0;
  logic       brk_req = 1'b0, wr_valid = 1'b0;
  logic [8:0] wr_data = '0;
  logic       wr_ready, tx, busy;
  int         errors = 0, checks = 0;

  always #5 clk = ~clk;

  serial_frame_tx uut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .cfg_wide(cfg_wide),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_lin_en(cfg_lin_en),
    .brk_req(brk_req), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .tx(tx), .busy(busy)
  );

  // {lin, wide, par, odd, data[8:0], expected slots[8:0], frame length[3:0]}
  localparam logic [25:0] VEC [10] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 9'h035, 9'h035, 4'd10},  // R2
    {1'b0, 1'b0, 1'b1, 1'b0, 9'h035, 9'h035, 4'd10},  // R3 R6 even
    {1'b0, 1'b0, 1'b1, 1'b1, 9'h035, 9'h0B5, 4'd10},  // R3 R6 odd
    {1'b0, 1'b0, 1'b1, 1'b0, 9'h0FF, 9'h0FF, 4'd10},  // R6
    {1'b0, 1'b0, 1'b1, 1'b1, 9'h0FF, 9'h07F, 4'd10},  // R6
    {1'b0, 1'b0, 1'b1, 1'b0, 9'h080, 9'h000, 4'd10},  // R3 top bit dropped
    {1'b0, 1'b1, 1'b0, 1'b0, 9'h1A5, 9'h1A5, 4'd11},  // R4
    {1'b0, 1'b1, 1'b1, 1'b0, 9'h135, 9'h035, 4'd11},  // R5
    {1'b0, 1'b1, 1'b1, 1'b1, 9'h0F3, 9'h1F3, 4'd11},  // R5 R6
    {1'b1, 1'b1, 1'b0, 1'b0, 9'h1A5, 9'h0A5, 4'd10}   // R12
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_word(input logic [8:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk) wr_valid = 1'b0;
  endtask

  task automatic pulse_brk();
    @(negedge clk) brk_req = 1'b1;
    @(negedge clk) brk_req = 1'b0;
  endtask

  function automatic logic [13:0] data_frame(input logic [8:0] slots, input int len);
    logic [13:0] fr = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < len - 2; i++) fr[i+1] = slots[i];
    return fr;
  endfunction

  task automatic run_part(input logic [13:0] fr, input int from, input int len, input string tag);
    for (int k = from; k < len; k++) begin
      do_tick();
      chk(tx === fr[k] && busy === 1'b1, tag, {busy, tx}, {1'b1, fr[k]});
    end
  endtask

  task automatic expect_idle(input string tag);
    do_tick();
    chk(tx === 1'b1 && busy === 1'b0, tag, {busy, tx}, 2'b01);
  endtask

  localparam logic [13:0] BRK_FRAME = 14'b10_0000_0000_0000;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(tx === 1'b1 && busy === 1'b0 && wr_ready === 1'b1, "R1 reset",
        {wr_ready, busy, tx}, 3'b101);

    // Vector table: R2 R3 R4 R5 R6 R12
    for (int v = 0; v < 10; v++) begin
      {cfg_lin_en, cfg_wide, cfg_par_en, cfg_par_odd} = VEC[v][25:22];
      write_word(VEC[v][21:13]);
      run_part(data_frame(VEC[v][12:4], int'(VEC[v][3:0])), 0, int'(VEC[v][3:0]),
               $sformatf("R2-5/R6/R12 frame vec%0d", v));
      expect_idle("R1 idle after frame");
    end

    // R7: no tick, no movement
    {cfg_lin_en, cfg_wide, cfg_par_en, cfg_par_odd} = 4'b0000;
    write_word(9'h0C3);
    repeat (5) @(negedge clk);
    chk(tx === 1'b1 && busy === 1'b0, "R7 no tick", {busy, tx}, 2'b01);
    chk(wr_ready === 1'b0, "R8 ready low while held", wr_ready, 0);
    do_tick();
    chk(tx === 1'b0 && busy === 1'b1, "R7 start on first tick", {busy, tx}, 2'b10);
    chk(wr_ready === 1'b1, "R8 ready after load", wr_ready, 1);
    run_part(data_frame(9'h0C3, 10), 1, 10, "R7 frame");
    expect_idle("R7 idle");

    // R10: break ignored without line-bus mode
    pulse_brk();
    repeat (3) begin
      do_tick();
      chk(tx === 1'b1 && busy === 1'b0, "R10 break ignored", {busy, tx}, 2'b01);
    end

    // R9: break character
    cfg_lin_en = 1'b1;
    pulse_brk();
    run_part(BRK_FRAME, 0, 14, "R9 break");
    expect_idle("R9 idle after break");

    // R11 + R8: break mid-frame, waiting word sent after the break
    write_word(9'h055);
    do_tick();
    chk(tx === 1'b0, "R11 first frame start", tx, 0);
    write_word(9'h00F);
    chk(wr_ready === 1'b0, "R8 second word held", wr_ready, 0);
    run_part(data_frame(9'h055, 10), 1, 3, "R11 first frame");
    pulse_brk();
    run_part(data_frame(9'h055, 10), 3, 10, "R11 frame not cut");
    run_part(BRK_FRAME, 0, 14, "R11 break before waiting word");
    run_part(data_frame(9'h00F, 10), 0, 10, "R8 back-to-back word");
    expect_idle("R11 idle at end");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule